// File: doc/BRIEF.md
# Clause 22 Management Bus Master

This block is the station-side master of the two-wire PHY management bus. A single request carries the operation (read or write), a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit word. Because the address fields are five bits wide, one bus serves up to 32 PHYs with up to 32 registers each. The block derives the management clock from the system clock through an even divider. It drives the data line through a separate output enable, so a tri-state pad or an open-drain buffer with an external pull-up can sit outside the block.

Every access is a fixed 64-bit frame. It opens with a run of 32 ones. Sixteen control bits follow: the start pattern, the operation code, the PHY address, the register address and a two-bit turnaround. The frame closes with sixteen data bits. On a write the master drives the whole frame. On a read it lets go of the line at the turnaround, and the PHY then supplies the register contents, which the block shifts in and returns with a one-cycle completion pulse.

Top module: `mdio_master`

## Requirements
- R1: While no access is running, `mdio_oe` is 0, `mdc` is 0 and `busy` is 0; this holds after reset and between accesses.
- R2: `cmd_start` sampled high while idle latches the command; `busy` is high from the next cycle for exactly 64 x CLK_DIV cycles.
- R3: Each frame bit lasts CLK_DIV system cycles, with `mdc` low for the first CLK_DIV/2 and high for the last CLK_DIV/2; CLK_DIV must be even and at least 2, checked at elaboration.
- R4: Frame bits 0 to 31 are all 1 and are driven (`mdio_oe` = 1).
- R5: Frame bits 32 to 45 are, most significant bit first: start code 01, operation code (01 = write, 10 = read), PHY address, register address.
- R6: On a write, bits 46 and 47 are driven as 1 then 0, bits 48 to 63 carry `cmd_wdata` most significant bit first, and `mdio_oe` is 1 for all 64 bits.
- R7: On a read, `mdio_oe` is 0 from bit 46 to the end of the frame; `mdio_i` is sampled at each rising `mdc` edge of bits 48 to 63 and placed in `rd_data` most significant bit first.
- R8: `done` is high for exactly one cycle, in the first cycle after `busy` falls; `rd_data` holds the read result in that cycle.
- R9: `cmd_start` while `busy` is high is ignored; the running frame and its operation are unchanged.
- R10: If `cmd_start` is still high in the `done` cycle, the new command is accepted at that cycle's end, so `busy` returns after a single idle cycle.
- R11: `mdio_o` only changes on the system clock edge at which `mdc` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | Request an access; taken only while idle |
| cmd_write | input | 1 | 1 = write access, 0 = read access |
| cmd_phy | input | 5 | Target PHY address |
| cmd_reg | input | 5 | Target register address |
| cmd_wdata | input | 16 | Word to send on a write |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Word returned by the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line as seen on the pad |

## Verification
Two functions can land in one cycle: the end of an access, with its `done` pulse and the last falling `mdc` edge, and the acceptance of the next request when `cmd_start` is left high through that pulse. The bench holds the request line high across the end of a write, swaps the command fields to a read in the `done` cycle, and checks that `busy` returns one cycle later. It then rebuilds both frames from the line and compares each to the frame computed from its own fields. A second pairing places a stray request in the middle of a frame, and the frame captured on the line must match the original command bit for bit.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

   localparam int unsigned PHY_AW     = 5;
   localparam int unsigned REG_AW     = 5;
   localparam int unsigned DATA_W     = 16;
   localparam int unsigned PRE_BITS   = 32;
   localparam int unsigned CTRL_BITS  = 2 + 2 + PHY_AW + REG_AW + 2;
   localparam int unsigned FRAME_BITS = PRE_BITS + CTRL_BITS + DATA_W;
   localparam int unsigned TA_IDX     = PRE_BITS + CTRL_BITS - 2;
   localparam int unsigned RD_IDX     = PRE_BITS + CTRL_BITS;

   localparam logic [1:0] SOF_CODE = 2'b01;
   localparam logic [1:0] TA_CODE  = 2'b10;

   typedef enum logic [1:0] {
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10
   } mgmt_op_e;

   typedef enum logic {
      ST_IDLE,
      ST_SHIFT
   } seq_state_e;

   typedef logic [FRAME_BITS-1:0] frame_t;

   function automatic frame_t pack_frame(input mgmt_op_e op,
                                         input logic [PHY_AW-1:0] phy,
                                         input logic [REG_AW-1:0] rg,
                                         input logic [DATA_W-1:0] wd);
      return {{PRE_BITS{1'b1}}, SOF_CODE, op, phy, rg, TA_CODE, wd};
   endfunction

endpackage

// File: rtl/mdio_master_clk.sv
module mdio_master_clk #(
   parameter int unsigned CLK_DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_ev,
   output logic fall_ev
);
   localparam int unsigned HALF = CLK_DIV / 2;

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("mdio_master_clk: CLK_DIV must be even and at least 2");
      end

      if (CLK_DIV == 2) begin : g_toggle
         logic ph_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ph_q <= 1'b0;
            else        ph_q <= run ? ~ph_q : 1'b0;
         end
         assign rise_ev = run && !ph_q;
         assign fall_ev = run &&  ph_q;
      end else begin : g_count
         localparam int unsigned PH_W = $clog2(CLK_DIV);
         logic [PH_W-1:0] ph_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                ph_q <= '0;
            else if (!run || fall_ev)  ph_q <= '0;
            else                       ph_q <= ph_q + 1'b1;
         end
         assign rise_ev = run && (ph_q == PH_W'(HALF - 1));
         assign fall_ev = run && (ph_q == PH_W'(CLK_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                mdc <= 1'b0;
      else if (rise_ev)          mdc <= 1'b1;
      else if (fall_ev || !run)  mdc <= 1'b0;
   end

   AST_MDC_ONLY_WHEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      mdc |-> run); // R1

endmodule

// File: rtl/mdio_master_shift.sv
module mdio_master_shift
   import mdio_master_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  frame_t            frame_in,
   input  logic              rd_op,
   input  logic              rise_ev,
   input  logic              fall_ev,
   input  logic              mdio_i,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              last_bit,
   output logic [DATA_W-1:0] rd_word
);
   localparam int unsigned IDX_W = $clog2(FRAME_BITS);

   frame_t           sh_q;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] idx_nx;
   logic             in_rd_window;

   assign idx_nx       = idx_q + 1'b1;
   assign last_bit     = (idx_q == IDX_W'(FRAME_BITS - 1));
   assign in_rd_window = rd_op && (idx_q >= IDX_W'(RD_IDX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         idx_q   <= '0;
         mdio_o  <= 1'b1;
         mdio_oe <= 1'b0;
      end else if (load) begin
         sh_q    <= frame_in;
         idx_q   <= '0;
         mdio_o  <= frame_in[FRAME_BITS-1];
         mdio_oe <= 1'b1;
      end else if (fall_ev) begin
         if (last_bit) begin
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
         end else begin
            sh_q    <= {sh_q[FRAME_BITS-2:0], 1'b0};
            idx_q   <= idx_nx;
            mdio_o  <= sh_q[FRAME_BITS-2];
            mdio_oe <= !(rd_op && (idx_nx >= IDX_W'(TA_IDX)));
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        rd_word <= '0;
      else if (rise_ev && in_rd_window)  rd_word <= {rd_word[DATA_W-2:0], mdio_i};
   end

   AST_LOAD_DRIVES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> mdio_oe && mdio_o); // R4

endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_master_pkg::*;
#(
   parameter int unsigned CLK_DIV = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic              cmd_write,
   input  logic [PHY_AW-1:0] cmd_phy,
   input  logic [REG_AW-1:0] cmd_reg,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   seq_state_e state_q;
   logic       rd_op_q;
   logic       accept;
   logic       rise_ev;
   logic       fall_ev;
   logic       last_bit;
   frame_t     frame_in;

   assign busy     = (state_q == ST_SHIFT);
   assign accept   = (state_q == ST_IDLE) && cmd_start;
   assign frame_in = pack_frame(cmd_write ? OP_WRITE : OP_READ, cmd_phy, cmd_reg, cmd_wdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rd_op_q <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state_q)
            ST_IDLE: if (cmd_start) begin
               state_q <= ST_SHIFT;
               rd_op_q <= !cmd_write;
            end
            ST_SHIFT: if (fall_ev && last_bit) begin
               state_q <= ST_IDLE;
               done    <= 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   mdio_master_clk #(.CLK_DIV(CLK_DIV)) u_clk (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .mdc     (mdc),
      .rise_ev (rise_ev),
      .fall_ev (fall_ev)
   );

   mdio_master_shift u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .frame_in (frame_in),
      .rd_op    (rd_op_q),
      .rise_ev  (rise_ev),
      .fall_ev  (fall_ev),
      .mdio_i   (mdio_i),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .last_bit (last_bit),
      .rd_word  (rd_data)
   );

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdio_oe && !mdc)); // R1
   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R8
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_start) |=> $stable(rd_op_q)); // R9
   AST_RELEASE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(mdio_oe) && busy) |-> rd_op_q); // R7
   AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_o) |-> $fell(mdc)); // R11

endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
   localparam int DIV = 4;
   localparam int FB  = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0;
   logic        cmd_write = 1'b0;
   logic [4:0]  cmd_phy = '0;
   logic [4:0]  cmd_reg = '0;
   logic [15:0] cmd_wdata = '0;
   logic        busy, done, mdc, mdio_o, mdio_oe;
   logic [15:0] rd_data;
   logic        line;

   logic        phy_en = 1'b0;
   logic        phy_bit = 1'b1;
   logic        cur_read = 1'b0;
   logic [15:0] cur_pat = '0;

   logic [63:0] cap_line = '0;
   logic [63:0] cap_oe = '0;
   int          bitn = 0;
   int          busy_cyc = 0;
   int          per_cnt = 0;
   int          hi_cnt = 0;
   int          mdc_err = 0;
   int          chg_err = 0;
   logic        busy_q = 1'b0;
   logic        mdc_q = 1'b0;
   logic        mo_q = 1'b1;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   assign line = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

   mdio_master #(.CLK_DIV(DIV)) u_mdio_master (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_write(cmd_write),
      .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
      .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(line)
   );

   // line monitor and PHY model, evaluated away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy && !busy_q) begin
            bitn = 0; phy_en = 1'b0; busy_cyc = 0; per_cnt = 0; hi_cnt = 0;
         end
         if (busy) busy_cyc++;
         if (mdc && !mdc_q) begin
            if (bitn < FB) begin
               cap_line[63-bitn] = line;
               cap_oe[63-bitn]   = mdio_oe;
            end
            bitn++;
            if (bitn > 1 && per_cnt != DIV) mdc_err++;
            per_cnt = 0;
         end
         per_cnt++;
         if (mdc) hi_cnt++;
         if (!mdc && mdc_q) begin
            if (hi_cnt != DIV/2) mdc_err++;
            hi_cnt = 0;
            if (cur_read && bitn == 47) begin
               phy_en = 1'b1; phy_bit = 1'b0;
            end else if (cur_read && bitn >= 48 && bitn < FB) begin
               phy_en = 1'b1; phy_bit = cur_pat[63-bitn];
            end else begin
               phy_en = 1'b0;
            end
         end
         if ((mdio_o != mo_q) && !(!mdc && mdc_q)) chg_err++;
      end
      busy_q = busy; mdc_q = mdc; mo_q = mdio_o;
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_done(output bit ok);
      int n = 0;
      ok = 1'b0;
      while (n < FB*DIV + 16) begin
         @(negedge clk);
         n++;
         if (done) begin ok = 1'b1; break; end
      end
   endtask

   task automatic check_frame(input bit w, input logic [4:0] phy, input logic [4:0] rg,
                              input logic [15:0] data, input logic [15:0] pat, input string tag);
      logic [63:0] exp_f;
      logic [63:0] exp_oe;
      exp_f  = {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), phy, rg, 2'b10, (w ? data : pat)};
      exp_oe = w ? {64{1'b1}} : {{46{1'b1}}, {18{1'b0}}};
      chk(cap_line == exp_f, {tag, " R4 R5 frame bits"}, cap_line, exp_f);
      chk(cap_oe == exp_oe, w ? {tag, " R6 drive"} : {tag, " R7 release"}, cap_oe, exp_oe);
      chk(busy_cyc == FB*DIV, {tag, " R2 busy length"}, 64'(busy_cyc), 64'(FB*DIV));
      if (!w) chk(rd_data == pat, {tag, " R7 read word"}, 64'(rd_data), 64'(pat));
   endtask

   task automatic do_access(input bit w, input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] data, input logic [15:0] pat, input bit poke);
      bit ok;
      cur_read = !w; cur_pat = pat;
      @(negedge clk);
      cmd_write = w; cmd_phy = phy; cmd_reg = rg; cmd_wdata = data; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      chk(busy == 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
      if (poke) begin
         repeat (100) @(negedge clk);
         cmd_write = !w; cmd_phy = ~phy; cmd_reg = ~rg; cmd_wdata = ~data; cmd_start = 1'b1;
         @(negedge clk);
         cmd_start = 1'b0;
      end
      wait_done(ok);
      chk(ok, "R8 done seen", 64'(ok), 64'd1);
      check_frame(w, phy, rg, data, pat, poke ? "R9 stray start" : "sweep");
      chk(!busy && !mdio_oe && !mdc, "R1 idle at done", {61'd0, busy, mdio_oe, mdc}, 64'd0);
      @(negedge clk);
      chk(!done, "R8 single-cycle done", 64'(done), 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      bit ok;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !mdio_oe && !mdc && line, "R1 reset state",
          {59'd0, busy, done, mdio_oe, mdc, line}, 64'd1);

      for (int p = 0; p < 32; p++)
         do_access(1'b1, 5'(p), 5'(31 - p), 16'(p * 16'h0801) ^ 16'hA5C3, 16'h0, 1'b0);
      for (int r = 0; r < 32; r++)
         do_access(1'b0, 5'(r) ^ 5'h15, 5'(r), 16'h0, {5'(r), ~5'(r), 6'h2A}, 1'b0);
      do_access(1'b1, 5'h1F, 5'h1F, 16'h0000, 16'h0, 1'b0);
      do_access(1'b1, 5'h00, 5'h00, 16'hFFFF, 16'h0, 1'b0);
      do_access(1'b0, 5'h00, 5'h1F, 16'h0, 16'hFFFF, 1'b0);
      do_access(1'b0, 5'h1F, 5'h00, 16'h0, 16'h0000, 1'b0);
      do_access(1'b0, 5'h0A, 5'h11, 16'h0, 16'h8001, 1'b1);
      do_access(1'b1, 5'h05, 5'h0C, 16'h7E81, 16'h0, 1'b1);

      // R10: request held high across the done cycle
      cur_read = 1'b0; cur_pat = 16'h0;
      @(negedge clk);
      cmd_write = 1'b1; cmd_phy = 5'h03; cmd_reg = 5'h09; cmd_wdata = 16'h1234; cmd_start = 1'b1;
      wait_done(ok);
      chk(ok, "R10 first done", 64'(ok), 64'd1);
      check_frame(1'b1, 5'h03, 5'h09, 16'h1234, 16'h0, "R10 first");
      cur_read = 1'b1; cur_pat = 16'hBEEF;
      cmd_write = 1'b0; cmd_phy = 5'h07; cmd_reg = 5'h02; cmd_wdata = 16'h0;
      @(negedge clk);
      chk(busy == 1'b1 && !done, "R10 accepted after done cycle", {62'd0, busy, done}, 64'd2);
      cmd_start = 1'b0;
      wait_done(ok);
      chk(ok, "R10 second done", 64'(ok), 64'd1);
      check_frame(1'b0, 5'h07, 5'h02, 16'h0, 16'hBEEF, "R10 second");
      repeat (3) @(negedge clk);

      chk(mdc_err == 0, "R3 clock shape errors", 64'(mdc_err), 64'd0);
      chk(chg_err == 0, "R11 data change off falling edge", 64'(chg_err), 64'd0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule